// File: doc/BRIEF.md
# Bouncing LED Ball with Two-Player Scoring

This block is the playfield core of a one-dimensional LED ping pong game. A single lit LED, the ball, walks across a row of positions from the left end to the right end and back, forever. The ball moves only on a slow step pulse. That pulse comes from a modulo-N divider, which counts ticks arriving on a base tick input. All state runs on the single board clock, and no derived clock is used.

Each time the ball arrives at an end position, the player at the far side gains a point. The defending player can prevent that point by holding their paddle button on the step that brings the ball onto their end. Each score is a decimal digit that stops at nine. Each score drives an active-low seven-segment digit. Debouncing of the buttons and multiplexing of the displays are handled outside this block.

Top module: `led_pong_core`

## Requirements
- R1: After reset the ball position runs 0, 1, …, NPOS-1, NPOS-2, …, 0, 1, … and moves by exactly one place on each step pulse. It never stays at an end for two consecutive steps.
- R2: `led_o` has exactly one bit set. Bit k is set while the ball is at position k. Bit 0 is the far-left LED and bit NPOS-1 is the far-right LED.
- R3: A step pulse occurs one clock after every DIV_N-th cycle in which `base_tick` is high. Between step pulses the position does not change, whatever `base_tick` does.
- R4: The step that moves the ball onto position 0 adds one to the right player's score. This happens once per visit.
- R5: The step that moves the ball onto position NPOS-1 adds one to the left player's score. This happens once per visit.
- R6: If `pad_left` is high on the step that brings the ball onto position 0, the right player gets no point for that visit. If `pad_right` is high on the step that brings the ball onto position NPOS-1, the left player gets no point. A paddle press at any other time has no effect on either score or on the ball.
- R7: Each score stops at 9. Further awarded points leave it at 9.
- R8: The segment outputs are active-low. Bit 0 is segment a and bit 6 is segment g. The codes for the digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 (hexadecimal).
- R9: When `rst` is high at a clock edge, the block clears the divider count and any pending step, puts the ball at position 0 moving right, and sets both scores to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous reset, active high |
| base_tick | input | 1 | Slow tick counted by the internal divider |
| pad_left | input | 1 | Left player's paddle button, active high |
| pad_right | input | 1 | Right player's paddle button, active high |
| led_o | output | NPOS | One-hot ball position, bit 0 leftmost |
| seg_left_o | output | 7 | Left player's score digit, active-low, bit 0 = a |
| seg_right_o | output | 7 | Right player's score digit, active-low, bit 0 = a |

## Verification
The bench builds the block with NPOS=10 and DIV_N=3. With these values, a full round trip of the ball takes 54 busy base ticks. This puts many visits to both ends, saturation of both scores, and long paddle holds within a couple of thousand clocks. Driving `base_tick` in irregular patterns exercises divider wrap points that fall between and on end arrivals. Holding a paddle across several visits shows that only the blocked player's opponent is frozen.

// File: rtl/led_pong_pkg.sv
package led_pong_pkg;
    localparam int SCORE_W   = 4;
    localparam int SCORE_TOP = 9;
    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [6:0]         seg_t;
    localparam seg_t SEG_DARK = 7'h7F;
endpackage

// File: rtl/led_pong_div.sv
module led_pong_div #(
    parameter int DIV_N = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    output logic step_o
);
    localparam int CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_N - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             step;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        if (base_tick) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt  = '0;
                st_d.step = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign step_o = st_q.step;
endmodule

// File: rtl/led_pong_ball.sv
module led_pong_ball #(
    parameter int NPOS  = 10,
    parameter int POS_W = $clog2(NPOS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o,
    output logic             reach_left_o,
    output logic             reach_right_o
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NPOS - 1);
    localparam logic [POS_W-1:0] POS_NEAR = POS_W'(NPOS - 2);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             up;
    } ball_state_t;

    ball_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        reach_left_o  = 1'b0;
        reach_right_o = 1'b0;
        if (step_i) begin
            if (st_q.up) begin
                st_d.pos = st_q.pos + POS_W'(1);
                if (st_q.pos == POS_NEAR) begin
                    st_d.up       = 1'b0;
                    reach_right_o = 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos - POS_W'(1);
                if (st_q.pos == POS_W'(1)) begin
                    st_d.up      = 1'b1;
                    reach_left_o = 1'b1;
                end
            end
        end
        if (rst) begin
            st_d.pos      = '0;
            st_d.up       = 1'b1;
            reach_left_o  = 1'b0;
            reach_right_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos_o = st_q.pos;

    logic unused_last;
    assign unused_last = ^POS_LAST;
endmodule

// File: rtl/led_pong_score.sv
module led_pong_score
    import led_pong_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   award_i,
    input  logic   guard_i,
    output score_t score_o
);
    typedef struct packed {
        score_t pts;
    } score_state_t;

    score_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (award_i && !guard_i && (st_q.pts < SCORE_W'(SCORE_TOP))) begin
            st_d.pts = st_q.pts + SCORE_W'(1);
        end
        if (rst) begin
            st_d.pts = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign score_o = st_q.pts;
endmodule

// File: rtl/led_pong_seg7.sv
module led_pong_seg7
    import led_pong_pkg::*;
(
    input  score_t digit_i,
    output seg_t   seg_o
);
    always_comb begin
        case (digit_i)
            4'd0:    seg_o = 7'h40;
            4'd1:    seg_o = 7'h79;
            4'd2:    seg_o = 7'h24;
            4'd3:    seg_o = 7'h30;
            4'd4:    seg_o = 7'h19;
            4'd5:    seg_o = 7'h12;
            4'd6:    seg_o = 7'h02;
            4'd7:    seg_o = 7'h78;
            4'd8:    seg_o = 7'h00;
            4'd9:    seg_o = 7'h10;
            default: seg_o = SEG_DARK;
        endcase
    end
endmodule

// File: rtl/led_pong_core.sv
module led_pong_core
    import led_pong_pkg::*;
#(
    parameter int NPOS  = 10,
    parameter int DIV_N = 250
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            base_tick,
    input  logic            pad_left,
    input  logic            pad_right,
    output logic [NPOS-1:0] led_o,
    output logic [6:0]      seg_left_o,
    output logic [6:0]      seg_right_o
);
    localparam int POS_W = $clog2(NPOS);
    localparam int N_PLAYERS = 2;

    logic             step_w;
    logic [POS_W-1:0] pos_w;
    logic             reach_left_w;
    logic             reach_right_w;
    logic             award_w [N_PLAYERS];
    logic             guard_w [N_PLAYERS];
    score_t           score_w [N_PLAYERS];
    seg_t             seg_w   [N_PLAYERS];
    score_t           score_left_w;
    score_t           score_right_w;

    led_pong_div #(.DIV_N(DIV_N)) u_div (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .step_o    (step_w)
    );

    led_pong_ball #(.NPOS(NPOS), .POS_W(POS_W)) u_ball (
        .clk           (clk),
        .rst           (rst),
        .step_i        (step_w),
        .pos_o         (pos_w),
        .reach_left_o  (reach_left_w),
        .reach_right_o (reach_right_w)
    );

    // player 0 = left (scores at the right end), player 1 = right
    assign award_w[0] = reach_right_w;
    assign guard_w[0] = pad_right;
    assign award_w[1] = reach_left_w;
    assign guard_w[1] = pad_left;

    for (genvar p = 0; p < N_PLAYERS; p++) begin : g_player
        led_pong_score u_score (
            .clk     (clk),
            .rst     (rst),
            .award_i (award_w[p]),
            .guard_i (guard_w[p]),
            .score_o (score_w[p])
        );
        led_pong_seg7 u_seg (
            .digit_i (score_w[p]),
            .seg_o   (seg_w[p])
        );
    end

    for (genvar k = 0; k < NPOS; k++) begin : g_led
        assign led_o[k] = (pos_w == POS_W'(k));
    end

    assign score_left_w  = score_w[0];
    assign score_right_w = score_w[1];
    assign seg_left_o    = seg_w[0];
    assign seg_right_o   = seg_w[1];
endmodule

// File: rtl/led_pong_core_chk.sv
module led_pong_core_chk
    import led_pong_pkg::*;
#(
    parameter int NPOS  = 10,
    parameter int POS_W = $clog2(NPOS)
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input logic [POS_W-1:0] pos,
    input logic [NPOS-1:0]  led,
    input score_t           score_l,
    input score_t           score_r
);
    assert_one_lit_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(led) == 1);

    assert_move_by_one_R1: assert property (@(posedge clk) disable iff (rst)
        step |=> (pos == $past(pos) + POS_W'(1)) || (pos + POS_W'(1) == $past(pos)));

    assert_hold_between_steps_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));

    assert_right_gain_at_left_end_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(score_r) |-> (pos == '0) && (score_r == $past(score_r) + SCORE_W'(1)));

    assert_left_gain_at_right_end_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(score_l) |-> (pos == POS_W'(NPOS - 1)) && (score_l == $past(score_l) + SCORE_W'(1)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (score_l <= SCORE_W'(SCORE_TOP)) && (score_r <= SCORE_W'(SCORE_TOP)));
endmodule

bind led_pong_core led_pong_core_chk #(.NPOS(NPOS), .POS_W(POS_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step_w),
    .pos     (pos_w),
    .led     (led_o),
    .score_l (score_left_w),
    .score_r (score_right_w)
);

// File: tb/led_pong_core_tb.sv
module led_pong_core_tb;
    localparam int NPOS  = 10;
    localparam int DIV_N = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            base_tick = 1'b0;
    logic            pad_left = 1'b0;
    logic            pad_right = 1'b0;
    logic [NPOS-1:0] led_o;
    logic [6:0]      seg_left_o;
    logic [6:0]      seg_right_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    led_pong_core #(.NPOS(NPOS), .DIV_N(DIV_N)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .base_tick   (base_tick),
        .pad_left    (pad_left),
        .pad_right   (pad_right),
        .led_o       (led_o),
        .seg_left_o  (seg_left_o),
        .seg_right_o (seg_right_o)
    );

    function automatic logic [6:0] exp_seg(input int v);
        case (v)
            0: return 7'h40;  1: return 7'h79;  2: return 7'h24;
            3: return 7'h30;  4: return 7'h19;  5: return 7'h12;
            6: return 7'h02;  7: return 7'h78;  8: return 7'h00;
            9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_cnt = 0, m_pos = 0, m_sl = 0, m_sr = 0;
    bit m_up = 1'b1, m_step = 1'b0, m_ns, m_valid = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_step = 1'b0; m_pos = 0; m_up = 1'b1;
            m_sl = 0; m_sr = 0; m_valid = 1'b1;
        end else begin
            m_ns = base_tick && (m_cnt == DIV_N - 1);
            if (base_tick) m_cnt = (m_cnt == DIV_N - 1) ? 0 : m_cnt + 1;
            if (m_step) begin
                m_pos = m_up ? m_pos + 1 : m_pos - 1;
                if (m_pos == NPOS - 1) m_up = 1'b0;
                if (m_pos == 0) m_up = 1'b1;
                if (m_pos == 0 && !pad_left && m_sr < 9) m_sr++;
                if (m_pos == NPOS - 1 && !pad_right && m_sl < 9) m_sl++;
            end
            m_step = m_ns;
        end
        #2;
        if (m_valid && !finished) begin
            check("R1/R2/R3 led position", 16'(led_o), 16'(1 << m_pos));
            check("R4/R5/R6/R7/R8 left digit", 16'(seg_left_o), 16'(exp_seg(m_sl)));
            check("R4/R5/R6/R7/R8 right digit", 16'(seg_right_o), 16'(exp_seg(m_sr)));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    int saved_sr;
    int saved_sl;

    initial begin
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state visible at the ports
        check("R9 reset led", 16'(led_o), 16'h0001);
        check("R9 reset left digit", 16'(seg_left_o), 16'h0040);
        check("R9 reset right digit", 16'(seg_right_o), 16'h0040);

        // R3: no base ticks, ball holds
        cycles(20);
        check("R3 ball holds without ticks", 16'(led_o), 16'h0001);

        // R1 R4 R5: steady ticks, no paddles
        base_tick = 1'b1;
        cycles(120);

        // R3: irregular base ticks and random paddle noise
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            base_tick = ($urandom_range(0, 2) != 0);
            pad_left  = ($urandom_range(0, 9) == 0);
            pad_right = ($urandom_range(0, 9) == 0);
        end
        pad_left = 1'b0; pad_right = 1'b0;

        // R6: left paddle held across several left-end visits
        saved_sr = m_sr;
        saved_sl = m_sl;
        base_tick = 1'b1;
        pad_left = 1'b1;
        cycles(200);
        pad_left = 1'b0;
        check("R6 right score frozen by left paddle", 16'(seg_right_o), 16'(exp_seg(saved_sr)));
        check("R5 left score still grows", 16'(seg_left_o != exp_seg(saved_sl)), 16'h0001);

        // R7: long run until both scores saturate
        cycles(1300);
        check("R7 left saturates at 9", 16'(seg_left_o), 16'h0010);
        check("R7 right saturates at 9", 16'(seg_right_o), 16'h0010);
        cycles(200);
        check("R7 left stays at 9", 16'(seg_left_o), 16'h0010);

        // R9: reset in mid-game
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        base_tick = 1'b0;
        @(negedge clk);
        check("R9 mid-game reset led", 16'(led_o), 16'h0001);
        check("R9 mid-game reset left", 16'(seg_left_o), 16'h0040);
        check("R9 mid-game reset right", 16'(seg_right_o), 16'h0040);

        // R1: one step after reset moves the ball right
        base_tick = 1'b1;
        cycles(DIV_N + 1);
        base_tick = 1'b0;
        cycles(2);
        check("R1 first step goes right", 16'(led_o), 16'h0002);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule